// File: doc/BRIEF.md
# Cache write-allocate decision unit

This block decides whether a write that has missed the L1 data cache should allocate a line. Each write request carries an address and the state around it: a global cache-disable bit, a per-page cache-disable input, a test inhibit bit, and a memory-type code that the range registers have already decoded. It also carries the result of the sector lookup (tag hit, and whether the addressed line is valid) and a programmable allocate limit. One cycle after the request strobe, the block returns a registered one-bit decision together with a valid pulse.

The block keeps one piece of state, a cacheable-page register. A completed read-miss fill loads it with that fill's 4 KB page number. A later write to the same page is taken as a write to a known-cacheable page and allocates. A write also allocates when its sector is present but its line is not. Apart from those two cases, a write allocates when its address lies below the programmed limit and outside the fixed legacy hole from 640 KB to 1 MB. The cacheable-page rule and the sector rule override the hole and the limit. They never override the hard inhibits.

Top module: `wa_decide`

## Requirements
- R1: When cache_dis_i is 1, the registered decision alloc_o is 0, whatever the other inputs are.
- R2: When page_cd_i is 1, the decision is 0, whatever the other inputs are.
- R3: When test_inh_i is 1, the decision is 0, whatever the other inputs are.
- R4: mem_type_i uses 2'b00 for uncacheable, 2'b01 for write-combining, 2'b10 for write-through and 2'b11 for write-back. Codes 00 and 01 force the decision to 0. Codes 10 and 11 block nothing.
- R5: Reset leaves the cacheable-page register invalid. A cycle with fill_done_i high loads it with fill_page_i, which holds address bits [31:12]. When there is no inhibit, a write whose bits [31:12] equal the stored page allocates. A write sampled in the same cycle as a fill is compared against the page stored before that fill.
- R6: When there is no inhibit, a write with sect_tag_hit_i=1 and line_valid_i=0 allocates.
- R7: When there is no inhibit, a write whose address bits [31:22] are numerically below alloc_limit_i (4 MB units) allocates, provided the address is outside the hole. A limit of 0 never allows an allocation through this rule.
- R8: An address from 32'h000A_0000 through 32'h000F_FFFF never allocates through the limit rule.
- R9: A cacheable-page hit (R5) or a sector hit (R6) allocates even inside the hole or above the limit.
- R10: alloc_valid_o is high exactly in the cycle after a cycle in which wr_req_i was sampled high. alloc_o is 0 whenever alloc_valid_o is 0.
- R11: While rst_ni is low, and after reset, both outputs are 0 until a request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write-miss request strobe |
| wr_addr_i | input | 32 | Write byte address |
| cache_dis_i | input | 1 | Global cache disable |
| page_cd_i | input | 1 | Per-page cache disable for this write |
| test_inh_i | input | 1 | Test cache-inhibit bit |
| mem_type_i | input | 2 | Decoded memory type (00 UC, 01 WC, 10 WT, 11 WB) |
| sect_tag_hit_i | input | 1 | The write's address matches a valid sector tag |
| line_valid_i | input | 1 | The addressed line within that sector is valid |
| alloc_limit_i | input | 7 | Allocate limit in 4 MB units, 0 disables the limit rule |
| fill_done_i | input | 1 | A read-miss fill has completed |
| fill_page_i | input | 20 | Page number (address bits [31:12]) of the completed fill |
| alloc_valid_o | output | 1 | Decision valid pulse |
| alloc_o | output | 1 | Allocate decision |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4 KB pages, a 7-bit limit in 4 MB units and the fixed 640 KB to 1 MB hole. Because the limit is only 7 bits wide, the bench can sweep all 128 values. For each value it probes the last address below the limit, the first address at it, both edges of the hole and an address above the limit range. A second sweep crosses every combination of the three disable bits, the four memory types and the two sector inputs. It applies each combination at a cacheable-page address inside the hole, at a plain hole address and at an address below the limit. A fill that coincides with a write covers the rule that a write is compared against the page stored before that fill.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    MT_UC = 2'b00,
    MT_WC = 2'b01,
    MT_WT = 2'b10,
    MT_WB = 2'b11
  } mem_type_e;

  function automatic logic mt_blocks(input logic [1:0] mt);
    return (mt == MT_UC) || (mt == MT_WC);
  endfunction
endpackage

// File: rtl/wa_page_reg.sv
module wa_page_reg #(
  parameter int PN_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fill_i,
  input  logic [PN_W-1:0] fill_page_i,
  input  logic [PN_W-1:0] look_page_i,
  output logic            hit_o
);
  logic [PN_W-1:0] page_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      vld_q  <= 1'b0;
    end else if (fill_i) begin
      page_q <= fill_page_i;
      vld_q  <= 1'b1;
    end
  end

  assign hit_o = vld_q && (look_page_i == page_q);

  assert_page_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (vld_q && page_q == $past(fill_page_i)));
  assert_page_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> $stable(page_q));
endmodule

// File: rtl/wa_region_chk.sv
module wa_region_chk #(
  parameter int              ADDR_W    = 32,
  parameter int              LIM_W     = 7,
  parameter int              LIM_SHIFT = 22,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h000F_FFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              lim_ok_o,
  output logic              in_hole_o
);
  localparam int UPW = ADDR_W - LIM_SHIFT;

  logic [UPW-1:0] up;
  logic           below;

  assign up = addr_i[ADDR_W-1:LIM_SHIFT];

  generate
    if (UPW >= LIM_W) begin : g_wide_addr
      assign below = UPW'(limit_i) > up;
    end else begin : g_wide_lim
      assign below = limit_i > LIM_W'(up);
    end
  endgenerate

  assign lim_ok_o  = (|limit_i) && below;
  assign in_hole_o = (addr_i >= HOLE_LO) && (addr_i <= HOLE_HI);
endmodule

// File: rtl/wa_decide.sv
module wa_decide
  import wa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LIM_W     = 7,
  parameter int LIM_SHIFT = 22,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h000F_FFFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_req_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic                  cache_dis_i,
  input  logic                  page_cd_i,
  input  logic                  test_inh_i,
  input  logic [1:0]            mem_type_i,
  input  logic                  sect_tag_hit_i,
  input  logic                  line_valid_i,
  input  logic [LIM_W-1:0]      alloc_limit_i,
  input  logic                  fill_done_i,
  input  logic [ADDR_W-PAGE_BITS-1:0] fill_page_i,
  output logic                  alloc_valid_o,
  output logic                  alloc_o
);
  localparam int PN_W = ADDR_W - PAGE_BITS;

  logic hard_inh, page_hit, sect_alloc, lim_ok, in_hole, alloc_d;
  logic vld_q, res_q, armed_q;

  wa_page_reg #(.PN_W(PN_W)) u_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_i     (fill_done_i),
    .fill_page_i(fill_page_i),
    .look_page_i(wr_addr_i[ADDR_W-1:PAGE_BITS]),
    .hit_o      (page_hit)
  );

  wa_region_chk #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W), .LIM_SHIFT(LIM_SHIFT),
    .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
  ) u_region (
    .addr_i   (wr_addr_i),
    .limit_i  (alloc_limit_i),
    .lim_ok_o (lim_ok),
    .in_hole_o(in_hole)
  );

  // hard inhibits are never overridden
  assign hard_inh   = cache_dis_i | page_cd_i | test_inh_i | mt_blocks(mem_type_i);
  assign sect_alloc = sect_tag_hit_i & ~line_valid_i;
  assign alloc_d    = ~hard_inh & (page_hit | sect_alloc | (lim_ok & ~in_hole));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      res_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      vld_q   <= wr_req_i;
      res_q   <= wr_req_i & alloc_d;
      armed_q <= 1'b1;
    end
  end

  assign alloc_valid_o = vld_q;
  assign alloc_o       = res_q;

  assert_valid_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    alloc_valid_o == $past(wr_req_i));
  assert_alloc_qualified_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> alloc_valid_o);
  assert_global_cd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && $past(cache_dis_i)) |-> !alloc_o);
  assert_page_cd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && $past(page_cd_i)) |-> !alloc_o);
  assert_test_inh_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && $past(test_inh_i)) |-> !alloc_o);
  assert_mem_type_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && !$past(mem_type_i[1])) |-> !alloc_o);
  assert_sector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && $past(sect_tag_hit_i && !line_valid_i && !hard_inh)) |-> alloc_o);
  assert_hole_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && $past(in_hole && !page_hit && !sect_alloc)) |-> !alloc_o);
  assert_lim_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (alloc_valid_o && $past(alloc_limit_i == '0 && !page_hit && !sect_alloc)) |-> !alloc_o);
endmodule

// File: tb/tb_wa_decide.sv
`timescale 1ns/1ps
module tb_wa_decide;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_req_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic        cache_dis_i = 1'b0, page_cd_i = 1'b0, test_inh_i = 1'b0;
  logic [1:0]  mem_type_i = 2'b11;
  logic        sect_tag_hit_i = 1'b0, line_valid_i = 1'b0;
  logic [6:0]  alloc_limit_i = '0;
  logic        fill_done_i = 1'b0;
  logic [19:0] fill_page_i = '0;
  logic        alloc_valid_o, alloc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit pg_vld = 0;
  logic [19:0] pg = '0;

  always #2 clk_i = ~clk_i;

  wa_decide dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i),
    .cache_dis_i(cache_dis_i), .page_cd_i(page_cd_i), .test_inh_i(test_inh_i),
    .mem_type_i(mem_type_i), .sect_tag_hit_i(sect_tag_hit_i), .line_valid_i(line_valid_i),
    .alloc_limit_i(alloc_limit_i), .fill_done_i(fill_done_i), .fill_page_i(fill_page_i),
    .alloc_valid_o(alloc_valid_o), .alloc_o(alloc_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic model(input logic [31:0] a);
    logic inh, ph, sh, lim, hole;
    inh  = cache_dis_i | page_cd_i | test_inh_i | (mem_type_i < 2'd2);
    ph   = pg_vld && (a[31:12] == pg);
    sh   = sect_tag_hit_i && !line_valid_i;
    lim  = (alloc_limit_i != 0) && ((a >> 22) < {25'd0, alloc_limit_i});
    hole = (a >= 32'h000A_0000) && (a <= 32'h000F_FFFF);
    return !inh && (ph || sh || (lim && !hole));
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    if (cache_dis_i) return "R1";
    if (page_cd_i) return "R2";
    if (test_inh_i) return "R3";
    if (mem_type_i < 2'd2) return "R4";
    if (pg_vld && a[31:12] == pg) return "R9";
    if (sect_tag_hit_i && !line_valid_i) return "R6";
    return "R8";
  endfunction

  // request at negedge; registered decision visible at the next negedge
  task automatic do_write(input logic [31:0] a, input string tag);
    logic e;
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_addr_i = a;
    e = model(a);
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk({tag, " valid"}, alloc_valid_o, 1'b1);
    chk({tag, " alloc"}, alloc_o, e);
  endtask

  task automatic do_fill(input logic [19:0] p);
    @(negedge clk_i);
    fill_done_i = 1'b1; fill_page_i = p;
    @(negedge clk_i);
    fill_done_i = 1'b0;
    pg = p; pg_vld = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 reset valid", alloc_valid_o, 1'b0);
    chk("R11 reset alloc", alloc_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R11 idle valid", alloc_valid_o, 1'b0);
    chk("R11 idle alloc", alloc_o, 1'b0);

    // page register invalid after reset: page 0 must not hit
    do_write(32'h0000_0100, "R5 invalid after reset");
    // R10: single-cycle pulse
    @(negedge clk_i);
    chk("R10 pulse ends valid", alloc_valid_o, 1'b0);
    chk("R10 pulse ends alloc", alloc_o, 1'b0);

    // R7/R8: full limit sweep
    for (int l = 0; l < 128; l++) begin
      alloc_limit_i = 7'(l);
      if (l > 0) do_write((32'(l) << 22) - 32'd1, "R7 below limit");
      do_write(32'(l) << 22, "R7 at limit");
      do_write(32'h000A_0000, "R8 hole low edge");
      do_write(32'h000F_FFFF, "R8 hole high edge");
      do_write(32'h0009_FFFF, "R7 below hole");
      do_write(32'h0010_0000, "R7 above hole");
      do_write(32'h2000_0000, "R7 upper bits");
    end

    // R5: fill, then hit in hole
    alloc_limit_i = '0;
    do_fill(20'h000B5);
    do_write(32'h000B_5FFC, "R5 page hit");
    do_write(32'h000B_6000, "R5 next page");
    // write coinciding with fill uses old page
    @(negedge clk_i);
    fill_done_i = 1'b1; fill_page_i = 20'h000C7;
    wr_req_i = 1'b1; wr_addr_i = 32'h000C_7010;
    @(negedge clk_i);
    fill_done_i = 1'b0; wr_req_i = 1'b0;
    chk("R5 same-cycle fill valid", alloc_valid_o, 1'b1);
    chk("R5 same-cycle fill alloc", alloc_o, 1'b0);
    pg = 20'h000C7;
    do_write(32'h000C_7010, "R5 after fill");
    do_fill(20'h000B5);

    // combination sweep
    alloc_limit_i = 7'd2;
    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          for (int a = 0; a < 3; a++) begin
            logic [31:0] ad;
            cache_dis_i = k[0]; page_cd_i = k[1]; test_inh_i = k[2];
            mem_type_i = 2'(m);
            sect_tag_hit_i = s[0]; line_valid_i = s[1];
            ad = (a == 0) ? 32'h000B_5040 : (a == 1) ? 32'h000E_0000 : 32'h0030_0000;
            do_write(ad, tag_of(ad));
          end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule